// File: doc/BRIEF.md
# DMA Channel Sequencer

This block is the control state machine of one DMA channel. It walks a channel through its descriptor life cycle: it checks the descriptor, polls an operand if the descriptor asks for one, moves the data, and then handles completion. The data movement itself happens elsewhere. The datapath reports back through a check-result strobe, a poll-match strobe and a transfer-done strobe. The sequencer answers with enables, a visible state code and sticky status bits.

Software acts on the channel through single-cycle command pulses: start, stop, flush, request-flush, halt, resume and abort. When a descriptor completes and is not the last one, a two-bit setting picks the follow-up action:

- stop, with a status bit;
- suspend until resume, with a status bit;
- chain to the next descriptor, with a status bit;
- chain to the next descriptor silently.

The trigger mode decides two things. It decides whether the data phase waits for a handshake request. It also decides whether halt is honoured. Halt is refused in internal-event mode.

Top module: `chan_ctrl_fsm`

## Requirements
- R1: After reset, `stateCode` is 0 (idle), and `sts`, `irq`, `xferEn`, `stopBusy` and `hsPending` are all 0. The state codes are: idle 0, descriptor check 1, operand poll 2, data transfer 3, stop 4, halt 5, done 6.
- R2: A `cmdStart` pulse in idle moves the channel to state 1 at the next edge. A `chkValid` pulse with `chkOk`=1 and `pollNeed`=0 moves it to 3. A `xferDone` pulse moves it to 6. From 6 with `lastDesc`=1 it goes to 0 and sets status bits 14 (last descriptor) and 15 (each descriptor).
- R3: A good check with `pollNeed`=1 moves the channel to state 2. It stays in 2 until a `pollMatch` pulse, which moves it to 3.
- R4: A `chkValid` pulse with `chkOk`=0 in state 1 returns the channel to 0 and sets no status bit.
- R5: From state 6 with `lastDesc`=0, `evtCtl` selects the next state:
  - 0 goes to 4 and then to 0, and sets bit 15;
  - 1 goes to 5 and sets bit 15, and a `cmdResume` then moves the channel to 1;
  - 2 goes to 1 and sets bit 15;
  - 3 goes to 1 and sets no bit.
- R6: When `trigMode` is not 3, a `cmdHalt` in state 1, 2 or 3 moves the channel to 5 and sets bit 19. A later `cmdResume` returns it to the state it left.
- R7: When `trigMode` is 3 (internal event), a `cmdHalt` is ignored. The state is unchanged and bit 19 stays 0.
- R8: `cmdStop` in any state other than idle or stop raises `stopBusy` at the next edge. Outside state 3, the channel enters 4 one edge later and sets bit 16. In state 3 it waits for `xferDone`, then enters 4, and no completion bit is set. The edge after 4 gives state 0 and clears `stopBusy`. In idle, `cmdStop` has no effect.
- R9: `cmdFlush` in state 2 or 3 moves the channel straight to 1 (the next descriptor) and sets bit 17.
- R10: An `hsReq` pulse sets `hsPending`. A `cmdReqFlush` clears `hsPending` and sets bit 18, in any state.
- R11: `xferEn` is 1 exactly when the state is 3 and either `trigMode` is 3 or `hsPending` is 1. A `xferDone` in state 3 clears `hsPending`.
- R12: `cmdAbort` in any state other than idle returns the channel to 0 at the next edge and sets bit 20. It also clears `stopBusy` and does not wait for `xferDone`. In idle it does nothing.
- R13: Status bits are sticky. Writing 1 to the matching `stsClr` bit clears a status bit, but a new event in the same cycle wins over the clear. `irq` is the OR of `sts & intEn`, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Start pulse |
| cmdStop | input | 1 | Stop pulse |
| cmdFlush | input | 1 | Skip to next descriptor pulse |
| cmdReqFlush | input | 1 | Drop pending handshake pulse |
| cmdHalt | input | 1 | Halt pulse |
| cmdResume | input | 1 | Resume pulse |
| cmdAbort | input | 1 | Abort pulse |
| trigMode | input | 2 | 0 hardware, 1 software, 2 timer, 3 internal event |
| evtCtl | input | 2 | Completion action for a descriptor that is not the last |
| lastDesc | input | 1 | Current descriptor is the last one |
| pollNeed | input | 1 | Descriptor requires operand poll |
| chkValid | input | 1 | Descriptor check finished |
| chkOk | input | 1 | Descriptor check passed |
| pollMatch | input | 1 | Polled operand matched |
| xferDone | input | 1 | Datapath finished the descriptor |
| hsReq | input | 1 | Handshake request pulse |
| intEn | input | 32 | Interrupt enable mask |
| stsClr | input | 32 | Write-one-to-clear for status |
| stateCode | output | 3 | Current state code |
| chkEn | output | 1 | Descriptor check active |
| pollEn | output | 1 | Operand poll active |
| xferEn | output | 1 | Datapath may move data |
| stopBusy | output | 1 | Stop requested, not yet stopped |
| hsPending | output | 1 | Handshake request pending |
| sts | output | 32 | Sticky status bits |
| irq | output | 1 | Masked interrupt |

## Verification
Every state change and every status bit lands at the first clock edge that samples the causing pulse, with one exception. A stop outside the data phase is first latched into `stopBusy`, reaches state 4 one edge later, and reaches idle one edge after that. `irq` and `xferEn` are combinational, so they follow the same-cycle values of `sts`, `intEn`, `trigMode` and `hsPending`. The bench drives each pulse for exactly one cycle, right after a rising edge, and samples one time unit after the next edge. Each check is therefore placed at the edge count given above, and multi-edge cases such as the stop path are stepped one edge at a time.

// File: rtl/chan_ctrl_pkg.sv
package chan_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_POLL  = 3'd2,
    ST_XFER  = 3'd3,
    ST_STOP  = 3'd4,
    ST_HALT  = 3'd5,
    ST_DONE  = 3'd6
  } chanState_e;

  localparam int TRIG_W = 2;
  localparam logic [TRIG_W-1:0] TRIG_EVENT = 2'd3;

  localparam int EVT_W = 2;
  localparam logic [EVT_W-1:0] EVT_STOP     = 2'd0;
  localparam logic [EVT_W-1:0] EVT_SUSPEND  = 2'd1;
  localparam logic [EVT_W-1:0] EVT_CHAIN    = 2'd2;
  localparam logic [EVT_W-1:0] EVT_CHAIN_NI = 2'd3;

  // status bit positions (decoded by software)
  localparam int BIT_LAST   = 14;
  localparam int BIT_EVERY  = 15;
  localparam int BIT_STOP   = 16;
  localparam int BIT_FLUSH  = 17;
  localparam int BIT_RQFL   = 18;
  localparam int BIT_HALT   = 19;
  localparam int BIT_ABORT  = 20;

  // strobes from sequencer to status datapath
  typedef struct packed {
    logic evLast;
    logic evEvery;
    logic evStop;
    logic evFlush;
    logic evReqFlush;
    logic evHalt;
    logic evAbort;
    logic stopSet;
    logic stopAck;
    logic hsTake;
    logic inXfer;
  } seqStb_s;

endpackage

// File: rtl/chan_ctrl_seq.sv
module chan_ctrl_seq
  import chan_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdStop,
  input  logic              cmdFlush,
  input  logic              cmdReqFlush,
  input  logic              cmdHalt,
  input  logic              cmdResume,
  input  logic              cmdAbort,
  input  logic [TRIG_W-1:0] trigMode,
  input  logic [EVT_W-1:0]  evtCtl,
  input  logic              lastDesc,
  input  logic              pollNeed,
  input  logic              chkValid,
  input  logic              chkOk,
  input  logic              pollMatch,
  input  logic              xferDone,
  input  logic              stopPend,
  output chanState_e        stateQ,
  output seqStb_s           stb
);

  chanState_e nxtState, rsmQ, rsmNxt;
  logic haltOk;

  assign haltOk = cmdHalt && (trigMode != TRIG_EVENT);

  always_comb begin
    nxtState       = stateQ;
    rsmNxt         = rsmQ;
    stb            = '0;
    stb.evReqFlush = cmdReqFlush;
    stb.inXfer     = (stateQ == ST_XFER);
    stb.stopSet    = cmdStop && (stateQ != ST_IDLE) && (stateQ != ST_STOP);
    if (cmdAbort && stateQ != ST_IDLE) begin
      nxtState    = ST_IDLE;
      stb.evAbort = 1'b1;
    end else begin
      case (stateQ)
        ST_IDLE: if (cmdStart) nxtState = ST_CHECK;
        ST_STOP: begin
          nxtState    = ST_IDLE;
          stb.stopAck = 1'b1;
        end
        ST_XFER: begin
          stb.hsTake = xferDone;
          if (stopPend && xferDone) begin
            nxtState   = ST_STOP;
            stb.evStop = 1'b1;
          end else if (haltOk) begin
            nxtState   = ST_HALT;
            rsmNxt     = ST_XFER;
            stb.evHalt = 1'b1;
          end else if (cmdFlush) begin
            nxtState    = ST_CHECK;
            stb.evFlush = 1'b1;
          end else if (xferDone) begin
            nxtState = ST_DONE;
          end
        end
        default: begin
          if (stopPend) begin
            nxtState   = ST_STOP;
            stb.evStop = 1'b1;
          end else begin
            case (stateQ)
              ST_CHECK: begin
                if (haltOk) begin
                  nxtState   = ST_HALT;
                  rsmNxt     = ST_CHECK;
                  stb.evHalt = 1'b1;
                end else if (chkValid) begin
                  if (!chkOk)        nxtState = ST_IDLE;
                  else if (pollNeed) nxtState = ST_POLL;
                  else               nxtState = ST_XFER;
                end
              end
              ST_POLL: begin
                if (haltOk) begin
                  nxtState   = ST_HALT;
                  rsmNxt     = ST_POLL;
                  stb.evHalt = 1'b1;
                end else if (cmdFlush) begin
                  nxtState    = ST_CHECK;
                  stb.evFlush = 1'b1;
                end else if (pollMatch) begin
                  nxtState = ST_XFER;
                end
              end
              ST_HALT: if (cmdResume) nxtState = rsmQ;
              ST_DONE: begin
                if (lastDesc) begin
                  nxtState    = ST_IDLE;
                  stb.evLast  = 1'b1;
                  stb.evEvery = 1'b1;
                end else begin
                  case (evtCtl)
                    EVT_STOP: begin
                      nxtState    = ST_STOP;
                      stb.evEvery = 1'b1;
                    end
                    EVT_SUSPEND: begin
                      nxtState    = ST_HALT;
                      rsmNxt      = ST_CHECK;
                      stb.evEvery = 1'b1;
                    end
                    EVT_CHAIN: begin
                      nxtState    = ST_CHECK;
                      stb.evEvery = 1'b1;
                    end
                    default: nxtState = ST_CHECK;
                  endcase
                end
              end
              default: nxtState = ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      rsmQ   <= ST_CHECK;
    end else begin
      stateQ <= nxtState;
      rsmQ   <= rsmNxt;
    end
  end

endmodule

// File: rtl/chan_ctrl_stat.sv
module chan_ctrl_stat
  import chan_ctrl_pkg::*;
#(
  parameter int STS_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStb_s           stb,
  input  logic              hsReq,
  input  logic [TRIG_W-1:0] trigMode,
  input  logic [STS_W-1:0]  intEn,
  input  logic [STS_W-1:0]  stsClr,
  output logic              stopPend,
  output logic              hsPend,
  output logic              xferEn,
  output logic [STS_W-1:0]  stsQ,
  output logic              irq
);

  logic [STS_W-1:0] setVec;

  always_comb begin
    setVec             = '0;
    setVec[BIT_LAST]   = stb.evLast;
    setVec[BIT_EVERY]  = stb.evEvery;
    setVec[BIT_STOP]   = stb.evStop;
    setVec[BIT_FLUSH]  = stb.evFlush;
    setVec[BIT_RQFL]   = stb.evReqFlush;
    setVec[BIT_HALT]   = stb.evHalt;
    setVec[BIT_ABORT]  = stb.evAbort;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stsQ     <= '0;
      stopPend <= 1'b0;
      hsPend   <= 1'b0;
    end else begin
      stsQ <= (stsQ & ~stsClr) | setVec;
      if (stb.evAbort || stb.stopAck) stopPend <= 1'b0;
      else if (stb.stopSet)           stopPend <= 1'b1;
      if (stb.evReqFlush)  hsPend <= 1'b0;
      else if (hsReq)      hsPend <= 1'b1;
      else if (stb.hsTake) hsPend <= 1'b0;
    end
  end

  assign xferEn = stb.inXfer && ((trigMode == TRIG_EVENT) || hsPend);
  assign irq    = |(stsQ & intEn);

endmodule

// File: rtl/chan_ctrl_fsm.sv
module chan_ctrl_fsm
  import chan_ctrl_pkg::*;
#(
  parameter int STS_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdStop,
  input  logic              cmdFlush,
  input  logic              cmdReqFlush,
  input  logic              cmdHalt,
  input  logic              cmdResume,
  input  logic              cmdAbort,
  input  logic [1:0]        trigMode,
  input  logic [1:0]        evtCtl,
  input  logic              lastDesc,
  input  logic              pollNeed,
  input  logic              chkValid,
  input  logic              chkOk,
  input  logic              pollMatch,
  input  logic              xferDone,
  input  logic              hsReq,
  input  logic [STS_W-1:0]  intEn,
  input  logic [STS_W-1:0]  stsClr,
  output logic [2:0]        stateCode,
  output logic              chkEn,
  output logic              pollEn,
  output logic              xferEn,
  output logic              stopBusy,
  output logic              hsPending,
  output logic [STS_W-1:0]  sts,
  output logic              irq
);

  chanState_e stateQ;
  seqStb_s    stb;

  chan_ctrl_seq u_seq (
    .clk(clk), .rstN(rstN),
    .cmdStart(cmdStart), .cmdStop(cmdStop), .cmdFlush(cmdFlush),
    .cmdReqFlush(cmdReqFlush), .cmdHalt(cmdHalt), .cmdResume(cmdResume),
    .cmdAbort(cmdAbort), .trigMode(trigMode), .evtCtl(evtCtl),
    .lastDesc(lastDesc), .pollNeed(pollNeed), .chkValid(chkValid),
    .chkOk(chkOk), .pollMatch(pollMatch), .xferDone(xferDone),
    .stopPend(stopBusy), .stateQ(stateQ), .stb(stb)
  );

  chan_ctrl_stat #(.STS_W(STS_W)) u_stat (
    .clk(clk), .rstN(rstN), .stb(stb), .hsReq(hsReq),
    .trigMode(trigMode), .intEn(intEn), .stsClr(stsClr),
    .stopPend(stopBusy), .hsPend(hsPending), .xferEn(xferEn),
    .stsQ(sts), .irq(irq)
  );

  assign stateCode = stateQ;
  assign chkEn     = (stateQ == ST_CHECK);
  assign pollEn    = (stateQ == ST_POLL);

endmodule

// File: rtl/chan_ctrl_chk.sv
module chan_ctrl_chk #(
  parameter int STS_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdAbort,
  input logic             cmdHalt,
  input logic [1:0]       trigMode,
  input logic [1:0]       evtCtl,
  input logic             lastDesc,
  input logic [STS_W-1:0] stsClr,
  input logic [2:0]       stateCode,
  input logic             xferEn,
  input logic             stopBusy,
  input logic [STS_W-1:0] sts
);

  // R1: only the seven defined codes appear
  a_r1_state_legal: assert property (@(posedge clk) disable iff (!rstN)
    stateCode != 3'd7);

  // R12: abort outside idle lands in idle next edge
  a_r12_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAbort && stateCode != 3'd0) |=> (stateCode == 3'd0 && !stopBusy));

  // R7: halt never entered in internal-event mode except via suspend
  a_r7_halt_refused: assert property (@(posedge clk) disable iff (!rstN)
    (cmdHalt && trigMode == 2'd3 && stateCode != 3'd5 &&
     !(stateCode == 3'd6 && evtCtl == 2'd1 && !lastDesc)) |=> stateCode != 3'd5);

  // R8: stop request held until stop state reached
  a_r8_stop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stopBusy && stateCode != 3'd4 && !cmdAbort) |=> stopBusy);

  // R8: stop state leads to idle with request cleared
  a_r8_stop_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd4 && !cmdAbort) |=> (stateCode == 3'd0 && !stopBusy));

  // R11: data enable only in transfer state
  a_r11_xfer_gate: assert property (@(posedge clk) disable iff (!rstN)
    xferEn |-> stateCode == 3'd3);

  // R13: without a clear, no status bit falls
  a_r13_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (stsClr == '0) |=> ((sts & $past(sts)) == $past(sts)));

endmodule

bind chan_ctrl_fsm chan_ctrl_chk #(.STS_W(STS_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdAbort(cmdAbort), .cmdHalt(cmdHalt),
  .trigMode(trigMode), .evtCtl(evtCtl), .lastDesc(lastDesc),
  .stsClr(stsClr), .stateCode(stateCode), .xferEn(xferEn),
  .stopBusy(stopBusy), .sts(sts)
);

// File: tb/sim_chan_ctrl_fsm.sv
module sim_chan_ctrl_fsm;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN;
  logic cmdStart, cmdStop, cmdFlush, cmdReqFlush, cmdHalt, cmdResume, cmdAbort;
  logic [1:0] trigMode, evtCtl;
  logic lastDesc, pollNeed, chkValid, chkOk, pollMatch, xferDone, hsReq;
  logic [31:0] intEn, stsClr;
  logic [2:0] stateCode;
  logic chkEn, pollEn, xferEn, stopBusy, hsPending, irq;
  logic [31:0] sts;

  chan_ctrl_fsm u0 (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdStop(cmdStop),
    .cmdFlush(cmdFlush), .cmdReqFlush(cmdReqFlush), .cmdHalt(cmdHalt),
    .cmdResume(cmdResume), .cmdAbort(cmdAbort), .trigMode(trigMode),
    .evtCtl(evtCtl), .lastDesc(lastDesc), .pollNeed(pollNeed),
    .chkValid(chkValid), .chkOk(chkOk), .pollMatch(pollMatch),
    .xferDone(xferDone), .hsReq(hsReq), .intEn(intEn), .stsClr(stsClr),
    .stateCode(stateCode), .chkEn(chkEn), .pollEn(pollEn), .xferEn(xferEn),
    .stopBusy(stopBusy), .hsPending(hsPending), .sts(sts), .irq(irq)
  );

  localparam int P_START = 0, P_STOP = 1, P_FLUSH = 2, P_RQFL = 3, P_HALT = 4,
                 P_RESUME = 5, P_ABORT = 6, P_HSREQ = 7, P_CHKOK = 8,
                 P_CHKBAD = 9, P_MATCH = 10, P_DONE = 11;

  function automatic logic [31:0] bitv(input int b);
    return 32'h1 << b;
  endfunction

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit fin = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int k);
    case (k)
      P_START:  cmdStart = 1'b1;
      P_STOP:   cmdStop = 1'b1;
      P_FLUSH:  cmdFlush = 1'b1;
      P_RQFL:   cmdReqFlush = 1'b1;
      P_HALT:   cmdHalt = 1'b1;
      P_RESUME: cmdResume = 1'b1;
      P_ABORT:  cmdAbort = 1'b1;
      P_HSREQ:  hsReq = 1'b1;
      P_CHKOK:  begin chkValid = 1'b1; chkOk = 1'b1; end
      P_CHKBAD: begin chkValid = 1'b1; chkOk = 1'b0; end
      P_MATCH:  pollMatch = 1'b1;
      default:  xferDone = 1'b1;
    endcase
    tick();
    {cmdStart, cmdStop, cmdFlush, cmdReqFlush, cmdHalt, cmdResume, cmdAbort} = '0;
    {hsReq, chkValid, chkOk, pollMatch, xferDone} = '0;
  endtask

  task automatic clean();
    if (stateCode != 3'd0) pulse(P_ABORT);
    stsClr = '1;
    tick();
    stsClr = '0;
  endtask

  // reach state 1, 2 or 3
  task automatic reach(input int s);
    pollNeed = (s == 2);
    pulse(P_START);
    if (s != 1) pulse(P_CHKOK);
    pollNeed = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !fin) begin
      fin = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    {cmdStart, cmdStop, cmdFlush, cmdReqFlush, cmdHalt, cmdResume, cmdAbort} = '0;
    {hsReq, chkValid, chkOk, pollMatch, xferDone, lastDesc, pollNeed} = '0;
    trigMode = 2'd1; evtCtl = 2'd0; intEn = '1; stsClr = '0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    check("R1 state", stateCode, 0);
    check("R1 sts", sts, 0);
    check("R1 outs", {irq, xferEn, stopBusy, hsPending}, 0);

    // R2 + R11 normal pass with last descriptor
    pulse(P_START);
    check("R2 check state", stateCode, 1);
    check("R2 chkEn", chkEn, 1);
    pulse(P_CHKOK);
    check("R2 xfer state", stateCode, 3);
    check("R11 no handshake", xferEn, 0);
    pulse(P_HSREQ);
    check("R11 pending", hsPending, 1);
    check("R11 enable", xferEn, 1);
    lastDesc = 1'b1;
    pulse(P_DONE);
    check("R2 done state", stateCode, 6);
    check("R11 consumed", hsPending, 0);
    tick();
    lastDesc = 1'b0;
    check("R2 idle", stateCode, 0);
    check("R2 last+every", sts, bitv(14) | bitv(15));
    check("R13 irq on", irq, 1);
    intEn = '0;
    #1 check("R13 irq masked", irq, 0);
    intEn = bitv(14);
    #1 check("R13 irq bit14", irq, 1);
    intEn = '1;
    stsClr = bitv(14);
    tick();
    stsClr = '0;
    check("R13 w1c", sts, bitv(15));
    clean();

    // R11 internal-event trigger needs no handshake
    trigMode = 2'd3;
    reach(3);
    check("R11 event enable", xferEn, 1);
    clean();
    trigMode = 2'd1;

    // R4 failed check
    pulse(P_START);
    pulse(P_CHKBAD);
    check("R4 idle", stateCode, 0);
    check("R4 no sts", sts, 0);

    // R3 poll
    reach(2);
    check("R3 poll", stateCode, 2);
    check("R3 pollEn", pollEn, 1);
    tick(); tick();
    check("R3 wait", stateCode, 2);
    pulse(P_MATCH);
    check("R3 to xfer", stateCode, 3);
    pulse(P_ABORT);
    check("R12 abort xfer", stateCode, 0);
    check("R12 abort bit", sts, bitv(20));
    clean();
    pulse(P_ABORT);
    check("R12 idle abort ignored", sts, 0);

    // R5 completion actions
    for (int e = 0; e < 4; e++) begin
      evtCtl = 2'(e);
      reach(3);
      pulse(P_DONE);
      check("R5 done", stateCode, 6);
      tick();
      check("R5 next state", stateCode, (e == 0) ? 4 : (e == 1) ? 5 : 1);
      check("R5 status", sts, (e == 3) ? 0 : bitv(15));
      if (e == 0) begin tick(); check("R5 stop to idle", stateCode, 0); end
      if (e == 1) begin pulse(P_RESUME); check("R5 resume", stateCode, 1); end
      clean();
    end
    evtCtl = 2'd0;

    // R6 halt/resume, R7 halt refused
    for (int t = 0; t < 4; t++) begin
      for (int s = 1; s < 4; s++) begin
        trigMode = 2'(t);
        reach(s);
        pulse(P_HALT);
        if (t != 3) begin
          check("R6 halted", stateCode, 5);
          check("R6 halt bit", sts, bitv(19));
          pulse(P_RESUME);
          check("R6 resumed", stateCode, 3'(s));
        end else begin
          check("R7 unchanged", stateCode, 3'(s));
          check("R7 no bit", sts, 0);
        end
        clean();
      end
    end
    trigMode = 2'd1;

    // R8 stop outside transfer
    reach(1);
    pulse(P_STOP);
    check("R8 busy", stopBusy, 1);
    check("R8 not yet", stateCode, 1);
    tick();
    check("R8 stop state", stateCode, 4);
    check("R8 stop bit", sts, bitv(16));
    tick();
    check("R8 idle", stateCode, 0);
    check("R8 busy clear", stopBusy, 0);
    clean();

    // R8 stop inside transfer waits for done
    reach(3);
    pulse(P_STOP);
    tick(); tick();
    check("R8 waits", stateCode, 3);
    check("R8 still busy", stopBusy, 1);
    pulse(P_DONE);
    check("R8 stop after done", stateCode, 4);
    check("R8 only stop bit", sts, bitv(16));
    tick();
    check("R8 idle2", {stateCode, stopBusy}, 0);
    clean();

    // R8 stop in idle
    pulse(P_STOP);
    check("R8 idle no effect", {stateCode, stopBusy}, 0);
    check("R8 idle no bit", sts, 0);

    // R12 abort while stop pending
    reach(3);
    pulse(P_STOP);
    pulse(P_ABORT);
    check("R12 abort clears stop", {stateCode, stopBusy}, 0);
    check("R12 bit", sts, bitv(20));
    clean();

    // R9 flush
    reach(3);
    pulse(P_FLUSH);
    check("R9 xfer flush", stateCode, 1);
    check("R9 bit", sts, bitv(17));
    clean();
    reach(2);
    pulse(P_FLUSH);
    check("R9 poll flush", stateCode, 1);
    clean();

    // R10 request flush, R13 set wins over clear
    pulse(P_HSREQ);
    check("R10 pending", hsPending, 1);
    stsClr = '1;
    pulse(P_RQFL);
    stsClr = '0;
    check("R10 cleared", hsPending, 0);
    check("R13 set wins", sts, bitv(18));

    fin = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule